// File: doc/BRIEF.md
# USB Host Receive Babble Guard

This block sits between the receive datapath of a USB host port and the receive FIFO. Every received byte arrives as a beat with start-of-packet and end-of-packet markers. The block forwards the byte to the FIFO only while the packet stays within the channel's maximum packet size and the port is still enabled. It watches for two faults. The first is a packet that runs longer than its maximum size. The second is receive traffic that is still present inside the end-of-frame guard window just before the next frame start.

A packet overrun is contained to that packet. Writing stops at the first excess byte, and at end of packet the FIFO write pointer is rolled back to the checkpoint taken at packet start. A frame overrun is handled as a port fault. The whole FIFO is flushed, the port is disabled, and a token lockout holds until software issues a soft reset. An overcurrent rise also disables the port, but it sets no lockout. A live overcurrent status lets software tell the two causes of a port-disable interrupt apart.

The controller has five states. IDLE waits for a start beat. RECV forwards bytes. DROP discards bytes until end of packet. OFF means the port was disabled by overcurrent. LOCK means the port was disabled by frame overrun. The transitions are:
- IDLE→RECV on an in-limit start beat that is not the last.
- IDLE/RECV→DROP on the first excess byte when it is not the last.
- RECV/DROP→IDLE on end of packet.
- IDLE/RECV/DROP→LOCK on any beat inside the guard window.
- IDLE/RECV/DROP→OFF on an overcurrent rise.
- OFF/LOCK→IDLE only on soft reset.

Top module: `rx_babble_guard`

## Requirements
- R1: Each byte of a packet, up to and including byte number max_pkt, appears on fifo_wr_en/fifo_wr_data one cycle after its beat.
- R2: The first byte beyond max_pkt, and every later byte of that packet, is not written.
- R3: At the end of a packet that overran, fifo_rollback and irq_babble pulse for one cycle, one cycle after the end beat, and sts_babble (status bit 0) sets. This holds also when the excess byte is itself the end beat.
- R4: A beat in IDLE without rx_sop is ignored, and nothing is written.
- R5: A beat with eof2_window high, while the port is enabled, produces a one-cycle fifo_flush and irq_port one cycle later, sets sts_port_chg (status bit 1), and drops port_enabled.
- R6: After a frame overrun, token_inhibit stays high, port_enabled stays low and nothing is written until soft_reset. soft_reset re-enables the port and clears token_inhibit.
- R7: A rising overcurrent while the port is enabled drops port_enabled, pulses irq_port and sets sts_port_chg, without flush or token_inhibit. A partial packet in flight is rolled back. sts_overcurrent follows overcurrent one cycle later.
- R8: Writing sts_clr_we with sts_clr_mask bit 0 clears sts_babble, and bit 1 clears sts_port_chg. A set event in the same cycle wins over the clear.
- R9: When a frame overrun and a packet overrun fall in the same cycle, only the frame overrun acts: flush, no rollback and no irq_babble.
- R10: eof2_window with no beat has no effect.
- R11: After reset, port_enabled is 1 and every other output is 0.
- R12: With max_pkt equal to 0, the first byte of a packet is already an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Software reset: returns the controller to IDLE and re-enables the port |
| rx_valid | input | 1 | Received byte beat |
| rx_sop | input | 1 | Beat is the first byte of a packet |
| rx_eop | input | 1 | Beat is the last byte of a packet |
| rx_data | input | DW | Received byte |
| max_pkt | input | MAXP_W | Channel maximum packet size in bytes |
| eof2_window | input | 1 | Frame timer flag for the end-of-frame guard window |
| overcurrent | input | 1 | Port overcurrent level |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for the status bits |
| sts_clr_mask | input | 2 | Bits to clear: bit 0 babble, bit 1 port change |
| fifo_wr_en | output | 1 | FIFO write enable |
| fifo_wr_data | output | DW | FIFO write data |
| fifo_rollback | output | 1 | Restore the FIFO write pointer to the packet-start checkpoint |
| fifo_flush | output | 1 | Empty the whole FIFO |
| irq_babble | output | 1 | Packet overrun interrupt pulse |
| irq_port | output | 1 | Port-disabled interrupt pulse |
| sts_babble | output | 1 | Sticky packet overrun status |
| sts_port_chg | output | 1 | Sticky port-enable-changed status |
| sts_overcurrent | output | 1 | Live overcurrent status |
| port_enabled | output | 1 | Port enabled |
| token_inhibit | output | 1 | No further tokens may be issued |

## Verification
The hardest case to reach is a frame overrun that falls on the exact beat that would otherwise be the first excess byte. This case tests the priority between the two detection paths. The stimulus sends a packet of exactly max_pkt bytes and raises eof2_window on the very next beat. It also drives an overcurrent rise in the middle of a packet, so that the rollback on the OFF path can be observed. A soft reset follows each fault, and the checks confirm that reception resumes normally afterwards.

// File: rtl/babble_pkg.sv
package babble_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_OFF,
        ST_LOCK
    } guard_state_t;

    localparam int STS_BABBLE_BIT  = 0;
    localparam int STS_PORTCHG_BIT = 1;
    localparam int STS_W           = 2;

endpackage

// File: rtl/pkt_meter.sv
module pkt_meter #(
    parameter int MAXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic              advance,
    input  logic [MAXP_W-1:0] max_pkt,
    output logic              over
);
    localparam int CNT_W = MAXP_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;

    // Bytes already accepted before this beat; a start beat begins from zero.
    assign base = start ? '0 : cnt_q;
    assign over = base >= {1'b0, max_pkt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (advance && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import babble_pkg::*;
#(
    parameter int DW     = 8,
    parameter int MAXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_reset,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DW-1:0]     rx_data,
    input  logic              eof2_window,
    input  logic              ovc_rise,
    input  logic              over,
    output logic              meter_start,
    output logic              meter_advance,
    output logic              fifo_wr_en,
    output logic [DW-1:0]     fifo_wr_data,
    output logic              fifo_rollback,
    output logic              fifo_flush,
    output logic              port_enabled,
    output logic              token_inhibit,
    output logic              ev_pkt_babble,
    output logic              ev_port_down
);
    guard_state_t state_q, state_d;
    logic ev_write, ev_port_babble, ev_ovc, ev_ovc_rollback, take;

    // Next-state and event decode
    always_comb begin
        state_d         = state_q;
        ev_write        = 1'b0;
        ev_pkt_babble   = 1'b0;
        ev_port_babble  = 1'b0;
        ev_ovc          = 1'b0;
        ev_ovc_rollback = 1'b0;
        take            = 1'b0;
        meter_start     = 1'b0;
        meter_advance   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RECV, ST_DROP: begin
                if (rx_valid && eof2_window) begin
                    ev_port_babble = 1'b1;
                    state_d        = ST_LOCK;
                end else if (ovc_rise) begin
                    ev_ovc          = 1'b1;
                    ev_ovc_rollback = (state_q != ST_IDLE);
                    state_d         = ST_OFF;
                end else if (state_q == ST_DROP) begin
                    meter_advance = rx_valid;
                    if (rx_valid && rx_eop) begin
                        ev_pkt_babble = 1'b1;
                        state_d       = ST_IDLE;
                    end
                end else begin
                    take          = (state_q == ST_IDLE) ? (rx_valid && rx_sop) : rx_valid;
                    meter_start   = take && (state_q == ST_IDLE);
                    meter_advance = take && (state_q == ST_RECV);
                    if (take) begin
                        if (over) begin
                            ev_pkt_babble = rx_eop;
                            state_d       = rx_eop ? ST_IDLE : ST_DROP;
                        end else begin
                            ev_write = 1'b1;
                            state_d  = rx_eop ? ST_IDLE : ST_RECV;
                        end
                    end
                end
            end
            ST_OFF, ST_LOCK: begin
                state_d = state_q;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign ev_port_down = (ev_port_babble || ev_ovc) && !soft_reset;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (soft_reset) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr_en    <= 1'b0;
            fifo_wr_data  <= '0;
            fifo_rollback <= 1'b0;
            fifo_flush    <= 1'b0;
            port_enabled  <= 1'b1;
            token_inhibit <= 1'b0;
        end else begin
            fifo_wr_en    <= ev_write && !soft_reset;
            fifo_wr_data  <= rx_data;
            fifo_rollback <= (ev_pkt_babble || ev_ovc_rollback) && !soft_reset;
            fifo_flush    <= ev_port_babble && !soft_reset;
            if (soft_reset) begin
                port_enabled  <= 1'b1;
                token_inhibit <= 1'b0;
            end else begin
                if (ev_port_babble || ev_ovc) port_enabled  <= 1'b0;
                if (ev_port_babble)           token_inhibit <= 1'b1;
            end
        end
    end

    // R2: nothing leaves the DROP state towards the FIFO
    assert_drop_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |=> !fifo_wr_en);

    // R4: a stray beat in IDLE without start marker writes nothing
    assert_idle_stray_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && !rx_sop) |=> !fifo_wr_en);

    // R5: flush is a single-cycle pulse
    assert_flush_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

endmodule

// File: rtl/guard_status.sv
module guard_status
    import babble_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_pkt_babble,
    input  logic             ev_port_down,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    input  logic             overcurrent,
    output logic             irq_babble,
    output logic             irq_port,
    output logic             sts_babble,
    output logic             sts_port_chg,
    output logic             sts_overcurrent,
    output logic             ovc_rise
);
    logic [STS_W-1:0] sts_q, set_v, clr_v;

    assign set_v[STS_BABBLE_BIT]  = ev_pkt_babble;
    assign set_v[STS_PORTCHG_BIT] = ev_port_down;
    assign clr_v                  = clr_we ? clr_mask : '0;
    assign ovc_rise               = overcurrent && !sts_overcurrent;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q           <= '0;
            irq_babble      <= 1'b0;
            irq_port        <= 1'b0;
            sts_overcurrent <= 1'b0;
        end else begin
            sts_q           <= (sts_q & ~clr_v) | set_v;
            irq_babble      <= ev_pkt_babble;
            irq_port        <= ev_port_down;
            sts_overcurrent <= overcurrent;
        end
    end

    assign sts_babble   = sts_q[STS_BABBLE_BIT];
    assign sts_port_chg = sts_q[STS_PORTCHG_BIT];

    // R3: a babble interrupt is always backed by its sticky status
    assert_irq_has_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_babble |-> sts_babble);

    // R8: a set status bit stays until cleared
    assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_port_chg && !(clr_we && clr_mask[STS_PORTCHG_BIT])) |=> sts_port_chg);

endmodule

// File: rtl/rx_babble_guard.sv
module rx_babble_guard
    import babble_pkg::*;
#(
    parameter int DW     = 8,
    parameter int MAXP_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_reset,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [DW-1:0]     rx_data,
    input  logic [MAXP_W-1:0] max_pkt,
    input  logic              eof2_window,
    input  logic              overcurrent,
    input  logic              sts_clr_we,
    input  logic [1:0]        sts_clr_mask,
    output logic              fifo_wr_en,
    output logic [DW-1:0]     fifo_wr_data,
    output logic              fifo_rollback,
    output logic              fifo_flush,
    output logic              irq_babble,
    output logic              irq_port,
    output logic              sts_babble,
    output logic              sts_port_chg,
    output logic              sts_overcurrent,
    output logic              port_enabled,
    output logic              token_inhibit
);
    logic meter_start, meter_advance, over;
    logic ev_pkt_babble, ev_port_down, ovc_rise;

    pkt_meter #(.MAXP_W(MAXP_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (soft_reset),
        .start   (meter_start),
        .advance (meter_advance),
        .max_pkt (max_pkt),
        .over    (over)
    );

    guard_fsm #(.DW(DW), .MAXP_W(MAXP_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_reset    (soft_reset),
        .rx_valid      (rx_valid),
        .rx_sop        (rx_sop),
        .rx_eop        (rx_eop),
        .rx_data       (rx_data),
        .eof2_window   (eof2_window),
        .ovc_rise      (ovc_rise),
        .over          (over),
        .meter_start   (meter_start),
        .meter_advance (meter_advance),
        .fifo_wr_en    (fifo_wr_en),
        .fifo_wr_data  (fifo_wr_data),
        .fifo_rollback (fifo_rollback),
        .fifo_flush    (fifo_flush),
        .port_enabled  (port_enabled),
        .token_inhibit (token_inhibit),
        .ev_pkt_babble (ev_pkt_babble),
        .ev_port_down  (ev_port_down)
    );

    guard_status u_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .ev_pkt_babble   (ev_pkt_babble),
        .ev_port_down    (ev_port_down),
        .clr_we          (sts_clr_we),
        .clr_mask        (sts_clr_mask),
        .overcurrent     (overcurrent),
        .irq_babble      (irq_babble),
        .irq_port        (irq_port),
        .sts_babble      (sts_babble),
        .sts_port_chg    (sts_port_chg),
        .sts_overcurrent (sts_overcurrent),
        .ovc_rise        (ovc_rise)
    );

    // R6: the token lockout always comes with a disabled port
    assert_lock_port_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        token_inhibit |-> !port_enabled);

    // R6: the lockout only ends through soft reset
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (token_inhibit && !soft_reset) |=> token_inhibit);

    // R9: flush and rollback never fire together
    assert_flush_over_rollback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_flush && fifo_rollback));

endmodule

// File: tb/test_rx_babble_guard.sv
module test_rx_babble_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_reset = 1'b0;
    logic       rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0] rx_data = '0;
    logic [10:0] max_pkt = 11'd4;
    logic       eof2_window = 1'b0, overcurrent = 1'b0;
    logic       sts_clr_we = 1'b0;
    logic [1:0] sts_clr_mask = '0;
    logic       fifo_wr_en, fifo_rollback, fifo_flush, irq_babble, irq_port;
    logic [7:0] fifo_wr_data;
    logic       sts_babble, sts_port_chg, sts_overcurrent, port_enabled, token_inhibit;

    always #2 clk = ~clk;

    rx_babble_guard i_rx_babble_guard (
        .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .max_pkt(max_pkt), .eof2_window(eof2_window), .overcurrent(overcurrent),
        .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_rollback(fifo_rollback), .fifo_flush(fifo_flush),
        .irq_babble(irq_babble), .irq_port(irq_port),
        .sts_babble(sts_babble), .sts_port_chg(sts_port_chg),
        .sts_overcurrent(sts_overcurrent), .port_enabled(port_enabled),
        .token_inhibit(token_inhibit)
    );

    typedef struct {
        logic [9:0] flags; // wr,rb,fl,ib,ip,pen,tok,sb,sp,so
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0, checks = 0;
    logic e_pen = 1'b1, e_tok = 1'b0, e_sb = 1'b0, e_sp = 1'b0, e_so = 1'b0;
    bit   done = 1'b0;

    // Driver: apply one cycle of stimulus and queue the result it must produce
    task automatic step(input logic v, s, e, f, input logic [7:0] d,
                        input logic wr, rb, fl, ib, ip, input string tag);
        exp_t it;
        rx_valid = v; rx_sop = s; rx_eop = e; eof2_window = f; rx_data = d;
        it.flags = {wr, rb, fl, ib, ip, e_pen, e_tok, e_sb, e_sp, e_so};
        it.data  = d;
        it.tag   = tag;
        exp_q.push_back(it);
        @(negedge clk);
        soft_reset = 1'b0; sts_clr_we = 1'b0; sts_clr_mask = '0;
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare outputs just after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t it;
            logic [9:0] act;
            it  = exp_q.pop_front();
            act = {fifo_wr_en, fifo_rollback, fifo_flush, irq_babble, irq_port,
                   port_enabled, token_inhibit, sts_babble, sts_port_chg, sts_overcurrent};
            checks++;
            if (act !== it.flags || (it.flags[9] && fifo_wr_data !== it.data)) begin
                errors++;
                $display("FAIL %s: flags=%b data=%h expected flags=%b data=%h",
                         it.tag, act, fifo_wr_data, it.flags, it.data);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R11 reset state");
        // R1: in-limit packet
        step(1, 1, 0, 0, 8'hA0, 1, 0, 0, 0, 0, "R1 byte0");
        step(1, 0, 0, 0, 8'hA1, 1, 0, 0, 0, 0, "R1 byte1");
        step(1, 0, 0, 0, 8'hA2, 1, 0, 0, 0, 0, "R1 byte2");
        step(1, 0, 1, 0, 8'hA3, 1, 0, 0, 0, 0, "R1 last byte");
        // R4: stray beats outside a packet
        step(1, 0, 0, 0, 8'h11, 0, 0, 0, 0, 0, "R4 stray");
        step(1, 0, 1, 0, 8'h12, 0, 0, 0, 0, 0, "R4 stray eop");
        // R10: guard window without beat
        step(0, 0, 0, 1, 8'h00, 0, 0, 0, 0, 0, "R10 window no beat");
        // R2/R3: overrun, end one beat later
        step(1, 1, 0, 0, 8'hB0, 1, 0, 0, 0, 0, "R1 B0");
        step(1, 0, 0, 0, 8'hB1, 1, 0, 0, 0, 0, "R1 B1");
        step(1, 0, 0, 0, 8'hB2, 1, 0, 0, 0, 0, "R1 B2");
        step(1, 0, 0, 0, 8'hB3, 1, 0, 0, 0, 0, "R1 B3 at limit");
        step(1, 0, 0, 0, 8'hB4, 0, 0, 0, 0, 0, "R2 first excess byte");
        e_sb = 1;
        step(1, 0, 1, 0, 8'hB5, 0, 1, 0, 1, 0, "R3 rollback at eop");
        idle("R3 single-cycle pulse");
        sts_clr_we = 1; sts_clr_mask = 2'b01; e_sb = 0;
        idle("R8 clear babble");
        // R3 excess byte is the end beat, R8 set beats clear
        step(1, 1, 0, 0, 8'hC0, 1, 0, 0, 0, 0, "R1 C0");
        step(1, 0, 0, 0, 8'hC1, 1, 0, 0, 0, 0, "R1 C1");
        step(1, 0, 0, 0, 8'hC2, 1, 0, 0, 0, 0, "R1 C2");
        step(1, 0, 0, 0, 8'hC3, 1, 0, 0, 0, 0, "R1 C3");
        sts_clr_we = 1; sts_clr_mask = 2'b01; e_sb = 1;
        step(1, 0, 1, 0, 8'hC4, 0, 1, 0, 1, 0, "R3 excess on eop R8 set wins");
        sts_clr_we = 1; sts_clr_mask = 2'b01; e_sb = 0;
        idle("R8 clear babble again");
        // R12: zero maximum size
        max_pkt = 11'd0; e_sb = 1;
        step(1, 1, 1, 0, 8'hD0, 0, 1, 0, 1, 0, "R12 zero max");
        max_pkt = 11'd4; sts_clr_we = 1; sts_clr_mask = 2'b01; e_sb = 0;
        idle("R8 clear after R12");
        // R7: overcurrent mid packet
        step(1, 1, 0, 0, 8'hE0, 1, 0, 0, 0, 0, "R1 E0");
        overcurrent = 1; e_pen = 0; e_sp = 1; e_so = 1;
        step(1, 0, 0, 0, 8'hE1, 0, 1, 0, 0, 1, "R7 overcurrent rollback");
        step(1, 1, 0, 0, 8'hE2, 0, 0, 0, 0, 0, "R7 port off no write");
        overcurrent = 0; e_so = 0;
        idle("R7 overcurrent status follows");
        soft_reset = 1; e_pen = 1;
        idle("R7 soft reset re-enables");
        sts_clr_we = 1; sts_clr_mask = 2'b10; e_sp = 0;
        idle("R8 clear port change");
        // R5/R6: frame overrun mid packet
        step(1, 1, 0, 0, 8'hF0, 1, 0, 0, 0, 0, "R1 F0");
        step(1, 0, 0, 0, 8'hF1, 1, 0, 0, 0, 0, "R1 F1");
        e_pen = 0; e_tok = 1; e_sp = 1;
        step(1, 0, 0, 1, 8'hF2, 0, 0, 1, 0, 1, "R5 frame overrun");
        step(1, 0, 1, 0, 8'hF3, 0, 0, 0, 0, 0, "R6 locked no write");
        step(1, 1, 1, 0, 8'hF4, 0, 0, 0, 0, 0, "R6 locked new packet");
        idle("R6 lock holds");
        soft_reset = 1; e_pen = 1; e_tok = 0;
        idle("R6 soft reset releases");
        sts_clr_we = 1; sts_clr_mask = 2'b10; e_sp = 0;
        idle("R8 clear port change 2");
        // R9: window hits the first excess byte
        step(1, 1, 0, 0, 8'h50, 1, 0, 0, 0, 0, "R1 G0");
        step(1, 0, 0, 0, 8'h51, 1, 0, 0, 0, 0, "R1 G1");
        step(1, 0, 0, 0, 8'h52, 1, 0, 0, 0, 0, "R1 G2");
        step(1, 0, 0, 0, 8'h53, 1, 0, 0, 0, 0, "R1 G3");
        e_pen = 0; e_tok = 1; e_sp = 1;
        step(1, 0, 1, 1, 8'h54, 0, 0, 1, 0, 1, "R9 frame overrun wins");
        soft_reset = 1; e_pen = 1; e_tok = 0;
        idle("R6 release after R9");
        step(1, 1, 0, 0, 8'h60, 1, 0, 0, 0, 0, "R6 resumes H0");
        step(1, 0, 1, 0, 8'h61, 1, 0, 0, 0, 0, "R6 resumes H1");
        idle("final idle");
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule